// File: doc/BRIEF.md
# SD Host Single-Operation DMA Address Engine

This block produces the memory addresses for a simple, non-chained DMA transfer inside an SD host controller. Software loads a 32-bit start address, a block size, a buffer boundary and a block count. It then pulses `start`. The data path hands over one 32-bit word at a time through a valid/ready handshake. For each word it accepts, the engine shows the current address on `word_addr` and moves the address on by four bytes.

Each time the running address crosses a power-of-two buffer boundary, the engine stops accepting words and raises a one-cycle DMA interrupt. Software may then put a new buffer address in the address register. Writing the top byte of that register restarts the transfer, and so does a continue request. In both cases the transfer carries on from whatever address the register holds. At every stop, the address register points at the next byte still to be moved. The transfer ends when the block count runs out, and `busy` then drops.

Top module: `sdma_addr_engine`

## Requirements
- R1: After reset the address register, the size/count register, `busy`, `paused`, `dma_irq` and `word_ready` are all zero.
- R2: A word is accepted when `word_valid` and `word_ready` are both high. On acceptance `word_addr` shows the current address, and the register then advances by 4.
- R3: Let n be the boundary field (bits 14:12 of the size/count register), giving a boundary of 4096 << n bytes. Suppose an accepted word leaves the address with its low 12+n bits at zero, and the transfer is not finished. Then `paused` is high from the next cycle, and `word_ready` stays low while `paused` is high.
- R4: `dma_irq` is high for exactly one cycle, in the first cycle that `paused` is high.
- R5: While paused, a write to the address register (`wr_sel`=0) with byte lane 3 enabled clears `paused`, and so does `cont_req`. The transfer then continues from the address held in the register, including any bytes written while paused. A paused write that leaves out lane 3 updates the address but does not resume.
- R6: While a transfer is running and not paused, writes to the address register are ignored. While `busy` is high, writes to the size/count register are ignored.
- R7: The size/count register (`wr_sel`=1) holds the block size in bits 11:0, with bit 15 acting as size bit 12. `blk_bytes` shows the resulting 13-bit byte count, so 0x8000 gives 4096. One block holds `blk_bytes`/4 words, with a minimum of one word.
- R8: `start` sets `busy` only when `busy` is low and the block count is non-zero. `busy` clears after the last word of the last block. No pause and no interrupt follow that word, even when it lands on a boundary.
- R9: The block count sits in bits 31:16 of the size/count register. It can hold any value up to 65535, can be read back, and goes down by one at each completed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 address, 1 size/count |
| wr_be | input | 4 | Byte lane enables |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 address, 1 size/count |
| rd_data | output | 32 | Read data for the selected register |
| start | input | 1 | Begin a transfer |
| cont_req | input | 1 | Continue or resume a paused transfer |
| word_valid | input | 1 | Data path offers a word |
| word_ready | output | 1 | Engine accepts a word |
| word_addr | output | 32 | Address of the word being accepted |
| blk_bytes | output | 13 | Decoded block size in bytes |
| paused | output | 1 | Stopped at a buffer boundary |
| dma_irq | output | 1 | One-cycle boundary interrupt |
| busy | output | 1 | Transfer in progress |

## Verification
Most corrupted internal state shows up at the ports within one clock. A wrong address step appears on `word_addr` in the cycle after the bad acceptance. A wrong boundary decode either produces a stray `paused`/`dma_irq` pair or drops the expected one at the boundary word. A bad word-in-block or block counter is slower to surface. It shows only when `busy` falls early or late, which is at most one block length after the error. The bench therefore compares against a reference model on every cycle, so that a miscount is caught as soon as `busy` first diverges.

// File: rtl/sdma_addr_engine.sv
module sdma_addr_engine #(
  parameter int BND_BASE = 12,
  parameter int BND_W    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  input  logic        start,
  input  logic        cont_req,
  input  logic        word_valid,
  output logic        word_ready,
  output logic [31:0] word_addr,
  output logic [12:0] blk_bytes,
  output logic        paused,
  output logic        dma_irq,
  output logic        busy
);
  localparam int WPB_W = 11;

  logic [31:0]      addr_q;
  logic [15:0]      bsz_q, cnt_q;
  logic [WPB_W-1:0] wib_q;
  logic             busy_q, paused_q, irq_q;

  logic [BND_W-1:0] bnd_sel;
  logic [31:0]      bnd_mask, addr_nx;
  logic [WPB_W-1:0] wpb;
  logic             acc, last_word, fin, hit, resume, go, addr_wr_ok;

  assign blk_bytes  = {bsz_q[15], bsz_q[11:0]};
  assign bnd_sel    = bsz_q[BND_BASE +: BND_W];
  assign bnd_mask   = (32'd1 << (BND_BASE + int'(bnd_sel))) - 32'd1;
  assign wpb        = (blk_bytes[12:2] == '0) ? WPB_W'(1) : blk_bytes[12:2];
  assign word_ready = busy_q & ~paused_q;
  assign acc        = word_valid & word_ready;
  assign addr_nx    = addr_q + 32'd4;
  assign last_word  = (wib_q + WPB_W'(1)) == wpb;
  assign fin        = acc & last_word & (cnt_q == 16'd1);
  assign hit        = acc & ~fin & ((addr_nx & bnd_mask) == '0);
  assign resume     = paused_q & (cont_req | (wr_en & ~wr_sel & wr_be[3]));
  assign go         = start & ~busy_q & (cnt_q != '0);
  assign addr_wr_ok = ~busy_q | paused_q;

  assign word_addr = addr_q;
  assign paused    = paused_q;
  assign dma_irq   = irq_q;
  assign busy      = busy_q;
  assign rd_data   = rd_sel ? {cnt_q, bsz_q} : addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      bsz_q    <= '0;
      cnt_q    <= '0;
      wib_q    <= '0;
      busy_q   <= 1'b0;
      paused_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= hit;

      if (acc)
        addr_q <= addr_nx;
      else if (wr_en && !wr_sel && addr_wr_ok)
        for (int b = 0; b < 4; b++)
          if (wr_be[b]) addr_q[8*b +: 8] <= wr_data[8*b +: 8];

      if (wr_en && wr_sel && !busy_q) begin
        for (int b = 0; b < 2; b++)
          if (wr_be[b]) bsz_q[8*b +: 8] <= wr_data[8*b +: 8];
        for (int b = 0; b < 2; b++)
          if (wr_be[b+2]) cnt_q[8*b +: 8] <= wr_data[16+8*b +: 8];
      end else if (acc && last_word) begin
        cnt_q <= cnt_q - 16'd1;
      end

      if (go)
        wib_q <= '0;
      else if (acc)
        wib_q <= last_word ? '0 : wib_q + WPB_W'(1);

      if (go)       busy_q <= 1'b1;
      else if (fin) busy_q <= 1'b0;

      if (hit)         paused_q <= 1'b1;
      else if (resume) paused_q <= 1'b0;
    end
  end

  a_r3_pause_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_q) |-> ((addr_q & bnd_mask) == '0));
  a_r3_no_accept_paused: assert property (@(posedge clk) disable iff (!rst_n)
    paused_q |-> !word_ready);
  a_r4_irq_with_pause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $rose(paused_q));
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> addr_q == $past(addr_q) + 32'd4);
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !paused_q && !acc) |=> $stable(addr_q));
  a_r8_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (cnt_q == '0));
endmodule

// File: tb/sdma_addr_engine_tb.sv
module sdma_addr_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0, cont_req = 1'b0, word_valid = 1'b0;
  logic [31:0] rd_data, word_addr;
  logic [12:0] blk_bytes;
  logic        word_ready, paused, dma_irq, busy;

  int total = 0, bad = 0, cyc = 0, irqs = 0;
  bit en_valid = 1'b0;

  // reference model state
  logic [31:0] m_addr;
  logic [15:0] m_bsz, m_cnt;
  int          m_wib;
  bit          m_busy, m_paused, m_irq;

  sdma_addr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .start(start),
    .cont_req(cont_req), .word_valid(word_valid), .word_ready(word_ready),
    .word_addr(word_addr), .blk_bytes(blk_bytes), .paused(paused),
    .dma_irq(dma_irq), .busy(busy));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_bsz = '0; m_cnt = '0; m_wib = 0;
      m_busy = 0; m_paused = 0; m_irq = 0;
    end else begin
      logic [31:0] a;
      logic [15:0] c, s;
      int wib, wpb, bnd;
      bit bz, pz, ir, acc, done;
      a = m_addr; c = m_cnt; s = m_bsz; wib = m_wib;
      bz = m_busy; pz = m_paused; ir = 0; done = 0;
      wpb = ({m_bsz[15], m_bsz[11:0]}) / 4;
      if (wpb == 0) wpb = 1;
      bnd = 4096 << m_bsz[14:12];
      acc = m_busy && !m_paused && word_valid;
      if (wr_en && !wr_sel && (!m_busy || m_paused))
        for (int b = 0; b < 4; b++) if (wr_be[b]) a[8*b +: 8] = wr_data[8*b +: 8];
      if (wr_en && wr_sel && !m_busy) begin
        for (int b = 0; b < 2; b++) if (wr_be[b]) s[8*b +: 8] = wr_data[8*b +: 8];
        for (int b = 0; b < 2; b++) if (wr_be[b+2]) c[8*b +: 8] = wr_data[16+8*b +: 8];
      end
      if (m_paused && (cont_req || (wr_en && !wr_sel && wr_be[3]))) pz = 0;
      if (start && !m_busy && m_cnt != 0) begin bz = 1; wib = 0; end
      if (acc) begin
        a = m_addr + 4;
        wib = m_wib + 1;
        if (wib == wpb) begin
          wib = 0; c = m_cnt - 1;
          if (c == 0) begin bz = 0; done = 1; end
        end
        if (!done && (a % bnd) == 0) begin pz = 1; ir = 1; end
      end
      m_addr = a; m_cnt = c; m_bsz = s; m_wib = wib;
      m_busy = bz; m_paused = pz; m_irq = ir;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dma_irq) irqs++;
      chk("R2 word_addr", word_addr, m_addr);
      chk("R3 paused", {31'd0, paused}, {31'd0, m_paused});
      chk("R3 word_ready", {31'd0, word_ready}, {31'd0, m_busy && !m_paused});
      chk("R4 dma_irq", {31'd0, dma_irq}, {31'd0, m_irq});
      chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R7 blk_bytes", {19'd0, blk_bytes}, {19'd0, m_bsz[15], m_bsz[11:0]});
    end
    #1 word_valid = en_valid && ($urandom_range(0, 3) != 0);
  end

  always @(posedge clk) if (cyc > 100000) begin
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(bit sel, logic [3:0] be, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0; wr_be = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  task automatic pulse_cont();
    @(negedge clk); #1 cont_req = 1;
    @(negedge clk); #1 cont_req = 0;
  endtask

  task automatic rd(bit sel, output logic [31:0] v);
    @(negedge clk); #1 rd_sel = sel; #1 v = rd_data;
  endtask

  task automatic wait_pause();
    for (int i = 0; i < 20000 && !m_paused; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && m_busy; i++) @(negedge clk);
    #2;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 paused", {31'd0, paused}, 32'd0);
    chk("R1 dma_irq", {31'd0, dma_irq}, 32'd0);
    chk("R1 word_ready", {31'd0, word_ready}, 32'd0);
    rd(0, v); chk("R1 addr", v, 32'd0);
    rd(1, v); chk("R1 size/count", v, 32'd0);
    rst_n = 1;

    // 16-byte blocks, 3 blocks, 4 KiB boundary
    wr(1, 4'hF, {16'd3, 16'h0010});
    rd(1, v); chk("R9 readback", v, {16'd3, 16'h0010});
    chk("R7 size16", {19'd0, blk_bytes}, 32'd16);
    wr(0, 4'hF, 32'h0000_0FF0);
    en_valid = 1;
    pulse_start();
    wait_pause();
    #2 chk("R3 paused at boundary", word_addr, 32'h0000_1000);
    chk("R4 one irq", irqs, 1);
    en_valid = 1;
    wr(0, 4'h3, 32'h0000_2000);
    repeat (3) @(negedge clk);
    #2 chk("R5 lane0-1 write keeps pause", {31'd0, paused}, 32'd1);
    chk("R5 address rewritten", word_addr, 32'h0000_2000);
    pulse_cont();
    repeat (2) @(negedge clk);
    wr(0, 4'hF, 32'hDEAD_0000);
    wr(1, 4'hF, 32'h0009_0004);
    wait_idle();
    chk("R6 R2 end address", word_addr, 32'h0000_2020);
    rd(1, v); chk("R9 R6 count ran out, size kept", v, {16'd0, 16'h0010});

    // completion exactly on a boundary
    irqs = 0;
    wr(1, 4'hF, {16'd1, 16'h0008});
    wr(0, 4'hF, 32'h0000_1FF8);
    pulse_start();
    wait_idle();
    chk("R8 finish on boundary addr", word_addr, 32'h0000_2000);
    chk("R8 no irq at finish", irqs, 0);
    chk("R8 busy clear", {31'd0, busy}, 32'd0);

    // 16 KiB boundary, resume by top-byte write
    wr(1, 4'hF, {16'd2, 16'h2100});
    wr(0, 4'hF, 32'h0000_3FF0);
    pulse_start();
    wait_pause();
    #2 chk("R3 16K boundary", word_addr, 32'h0000_4000);
    wr(0, 4'h8, 32'h0500_0000);
    @(negedge clk);
    #2 chk("R5 top byte resumes", {31'd0, paused}, 32'd0);
    wait_idle();
    chk("R5 relocated end", word_addr, 32'h0500_41F0);

    // 4096-byte block via bit 15
    irqs = 0;
    wr(1, 4'hF, {16'd1, 16'h8000});
    chk("R7 size 4096", {19'd0, blk_bytes}, 32'd4096);
    wr(0, 4'hF, 32'h0001_0000);
    pulse_start();
    wait_idle();
    chk("R7 4096 block end", word_addr, 32'h0001_1000);
    chk("R8 no irq 4096", irqs, 0);

    // start with zero count is ignored
    en_valid = 0;
    wr(1, 4'hC, 32'h0000_0000);
    pulse_start();
    @(negedge clk);
    #2 chk("R8 zero count start", {31'd0, busy}, 32'd0);

    wr(1, 4'hC, 32'hFFFF_0000);
    rd(1, v); chk("R9 max count", v, 32'hFFFF_8000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule